// File: doc/BRIEF.md
# Two-Byte Conversion Result Read Port

This block sits between a converter's sequencer and an 8-bit host data bus. It holds the latest 13-bit two's-complement conversion result. The sequencer loads that result with a one-cycle valid strobe. The host then fetches the result as two byte reads. The first read returns the upper part of the result, with the sign copied into the spare top bits. The second read returns the lower eight bits.

The host strobes an active-low select and an active-low read. Both are assumed already synchronous to `clk`. While a read access is in progress, the block drives the bus and raises an output enable that stands in for tri-state buffers. When a read access begins, the block pulses a request that clears the interrupt flag. An internal byte pointer moves to the other byte when each access ends. The pointer returns to the upper byte whenever a fresh result is loaded, so a new result is always read upper byte first.

Top module: `rdport_top`

## Requirements
- R1: The 13-bit result is captured only in a cycle where `res_valid` is high; changes on `res_data` without the strobe do not alter the bytes later read out.
- R2: The first read after a result is loaded returns the upper byte: bus bits 4..0 carry result bits 12..8, and bus bits 7..5 each carry result bit 12 (the sign).
- R3: The read following an upper-byte read returns result bits 7..0 on bus bits 7..0.
- R4: The byte pointer moves to the other byte in the first cycle where an access (`cs_n` and `rd_n` both low) has ended, so a third read returns the upper byte again.
- R5: `bus_oe` is high in exactly the cycles that follow a cycle with `cs_n` and `rd_n` both low, and `bus_out` is all zeros whenever `bus_oe` is low.
- R6: `int_clr` is a single-cycle pulse that appears one cycle after the first cycle of each access.
- R7: A `res_valid` strobe sets the pointer back to the upper byte, even between the two reads of a pair.
- R8: `rd_n` low while `cs_n` is high causes no drive, no clear pulse and no pointer movement.
- R9: After synchronous reset, `bus_oe`, `bus_out` and `int_clr` are zero, the pointer selects the upper byte and the held result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Sequencer strobe: load `res_data` |
| res_data | input | 13 | Two's-complement result, bit 12 is the sign |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read |
| bus_out | output | 8 | Registered byte driven to the host |
| bus_oe | output | 1 | Output enable that models the tri-state buffers |
| int_clr | output | 1 | One-cycle request to clear the interrupt flag |

## Verification
The hardest case to reach is a new result that arrives between the upper and lower read of a pair. Here the pointer must fall back to the upper byte instead of moving on. The bench creates this case by reading one byte, strobing a new value, and then reading again. It then repeats the sequence with the strobe in the same cycle that the access ends, so that the reset of the pointer and its advance compete. A strobe-free change of `res_data` and a read with the select high are also placed between reads, so that their lack of effect shows in the next byte returned.

// File: rtl/rdport_pkg.sv
package rdport_pkg;
  typedef enum logic {SEL_HI = 1'b0, SEL_LO = 1'b1} byte_sel_e;
endpackage

// File: rtl/rdport_latch.sv
module rdport_latch #(
  parameter int RES_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] din,
  output logic [RES_W-1:0] hold
);
  always_ff @(posedge clk) begin
    if (rst)       hold <= '0;
    else if (load) hold <= din;
  end
endmodule

// File: rtl/rdport_ptr.sv
module rdport_ptr
  import rdport_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      access,
  output byte_sel_e sel,
  output logic      acc_q,
  output logic      acc_start
);
  logic acc_end;

  assign acc_start = access & ~acc_q;
  assign acc_end   = acc_q & ~access;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= SEL_HI;
      acc_q <= 1'b0;
    end else begin
      acc_q <= access;
      if (load)         sel <= SEL_HI;
      else if (acc_end) sel <= (sel == SEL_HI) ? SEL_LO : SEL_HI;
    end
  end
endmodule

// File: rtl/rdport_fmt.sv
module rdport_fmt
  import rdport_pkg::*;
#(
  parameter int RES_W = 13,
  parameter int BUS_W = 8
) (
  input  logic [RES_W-1:0] hold,
  input  byte_sel_e        sel,
  output logic [BUS_W-1:0] byte_o
);
  localparam int HI_W = RES_W - BUS_W;
  localparam int EXT  = BUS_W - HI_W;

  logic [BUS_W-1:0] hi_byte;
  logic [BUS_W-1:0] lo_byte;

  assign lo_byte = hold[BUS_W-1:0];

  generate
    if (EXT > 0) begin : g_ext
      assign hi_byte = {{EXT{hold[RES_W-1]}}, hold[RES_W-1:BUS_W]};
    end else begin : g_noext
      assign hi_byte = hold[RES_W-1 -: BUS_W];
    end
  endgenerate

  assign byte_o = (sel == SEL_HI) ? hi_byte : lo_byte;
endmodule

// File: rtl/rdport_top.sv
module rdport_top
  import rdport_pkg::*;
#(
  parameter int RES_W = 13,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  output logic             int_clr
);
  logic             access;
  logic [RES_W-1:0] hold;
  byte_sel_e        sel;
  logic             acc_q;
  logic             acc_start;
  logic [BUS_W-1:0] byte_sel;

  assign access = ~cs_n & ~rd_n;

  rdport_latch #(.RES_W(RES_W)) u_latch (
    .clk(clk), .rst(rst), .load(res_valid), .din(res_data), .hold(hold)
  );

  rdport_ptr u_ptr (
    .clk(clk), .rst(rst), .load(res_valid), .access(access),
    .sel(sel), .acc_q(acc_q), .acc_start(acc_start)
  );

  rdport_fmt #(.RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
    .hold(hold), .sel(sel), .byte_o(byte_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
      int_clr <= 1'b0;
    end else begin
      bus_oe  <= access;
      bus_out <= access ? byte_sel : '0;
      int_clr <= acc_start;
    end
  end
endmodule

// File: rtl/rdport_chk.sv
module rdport_chk
  import rdport_pkg::*;
#(
  parameter int RES_W = 13,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             res_valid,
  input logic             cs_n,
  input logic             rd_n,
  input logic [BUS_W-1:0] bus_out,
  input logic             bus_oe,
  input logic             int_clr,
  input byte_sel_e        sel,
  input logic [RES_W-1:0] hold
);
  // R5
  oe_follows_access_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(~cs_n & ~rd_n));
  // R5
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_out == '0));
  // R6
  clr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    int_clr |=> !int_clr);
  // R6
  clr_with_drive_chk: assert property (@(posedge clk) disable iff (rst)
    int_clr |-> bus_oe);
  // R7
  load_resets_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (sel == SEL_HI));
  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> $stable(hold));
  // R8
  no_drive_unselected_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !bus_oe && !int_clr);
endmodule

bind rdport_top rdport_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .cs_n(cs_n), .rd_n(rd_n),
  .bus_out(bus_out), .bus_oe(bus_oe), .int_clr(int_clr), .sel(sel), .hold(hold)
);

// File: tb/rdport_top_tb.sv
module rdport_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 13;
  localparam int BUS_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             res_valid = 1'b0;
  logic [RES_W-1:0] res_data = '0;
  logic             cs_n = 1'b1;
  logic             rd_n = 1'b1;
  logic [BUS_W-1:0] bus_out;
  logic             bus_oe;
  logic             int_clr;

  int tests = 0;
  int fails = 0;

  rdport_top #(.RES_W(RES_W), .BUS_W(BUS_W)) u_dut (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .cs_n(cs_n), .rd_n(rd_n), .bus_out(bus_out), .bus_oe(bus_oe), .int_clr(int_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_val = 0;
  bit m_lo = 0;
  bit m_prev = 0;
  int e_out = 0;
  bit e_oe = 0;
  bit e_clr = 0;
  bit model_on = 0;

  function automatic int hi_of(int v);
    int s;
    s = (v >> 12) & 1;
    return ((v >> 8) & 31) | (s ? 8'hE0 : 0);
  endfunction

  always @(posedge clk) begin
    bit acc;
    if (rst) begin
      m_val = 0; m_lo = 0; m_prev = 0; e_out = 0; e_oe = 0; e_clr = 0;
    end else begin
      acc   = !cs_n && !rd_n;
      e_oe  = acc;
      e_out = acc ? (m_lo ? (m_val & 255) : hi_of(m_val)) : 0;
      e_clr = acc && !m_prev;
      if (res_valid) begin
        m_val = int'(res_data); m_lo = 0;
      end else if (m_prev && !acc) begin
        m_lo = !m_lo;
      end
      m_prev = acc;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      check("R5 bus_oe", int'(bus_oe), int'(e_oe));
      check("R2/R3 bus_out", int'(bus_out), e_out);
      check("R6 int_clr", int'(int_clr), int'(e_clr));
    end
  end

  task automatic load(int v);
    res_data = RES_W'(v); res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // one-cycle access; returns the byte seen while driven
  task automatic rd_byte(output int b);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    b = int'(bus_out);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  bit timed_out = 0;
  initial begin
    #(CLK_PERIOD * 20000);
    timed_out = 1;
  end

  initial begin
    int b;
    @(negedge clk); @(negedge clk);
    // R9 reset state
    check("R9 oe", int'(bus_oe), 0);
    check("R9 out", int'(bus_out), 0);
    check("R9 clr", int'(int_clr), 0);
    rst = 1'b0;
    model_on = 1;
    @(negedge clk);
    rd_byte(b); check("R9 reset result hi", b, 0);

    // R2 R3 positive value
    load(13'h0ABC);
    rd_byte(b); check("R2 hi pos", b, 8'h0A);
    rd_byte(b); check("R3 lo pos", b, 8'hBC);
    // R4 third read wraps to hi
    rd_byte(b); check("R4 wrap hi", b, 8'h0A);
    rd_byte(b); check("R4 wrap lo", b, 8'hBC);

    // R2 negative value: sign extension
    load(13'h1F35);
    rd_byte(b); check("R2 hi neg", b, 8'hFF);
    rd_byte(b); check("R3 lo neg", b, 8'h35);
    load(13'h1000);
    rd_byte(b); check("R2 hi min", b, 8'hF0);
    rd_byte(b); check("R3 lo min", b, 8'h00);

    // R1 data change without strobe ignored
    res_data = 13'h0123;
    @(negedge clk);
    rd_byte(b); check("R1 hold hi", b, 8'hF0);
    rd_byte(b); check("R1 hold lo", b, 8'h00);

    // R7 new result mid-pair
    load(13'h0456);
    rd_byte(b); check("R7 first hi", b, 8'h04);
    load(13'h17A5);
    rd_byte(b); check("R7 back to hi", b, 8'hF7);
    rd_byte(b); check("R7 then lo", b, 8'hA5);

    // R7 strobe in the cycle the access ends
    rd_byte(b); check("R7 pre hi", b, 8'hF7);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check("R7 lo during", int'(bus_out), 8'hA5);
    cs_n = 1'b1; rd_n = 1'b1;
    res_data = 13'h0A5A; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    rd_byte(b); check("R7 collide hi", b, 8'h0A);

    // R8 rd low without select
    cs_n = 1'b1; rd_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R8 no oe", int'(bus_oe), 0);
      check("R8 no clr", int'(int_clr), 0);
    end
    rd_n = 1'b1;
    @(negedge clk);
    rd_byte(b); check("R8 ptr kept lo", b, 8'h5A);

    // R5 R6 long access: clear only once, oe throughout
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check("R6 clr first", int'(int_clr), 1);
    check("R5 oe on", int'(bus_oe), 1);
    @(negedge clk);
    check("R6 clr once", int'(int_clr), 0);
    check("R5 oe held", int'(bus_oe), 1);
    check("R4 stable in access", int'(bus_out), 8'h0A);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    check("R5 oe off", int'(bus_oe), 0);
    check("R5 idle zero", int'(bus_out), 0);
    rd_byte(b); check("R4 after long", b, 8'h5A);

    repeat (3) @(negedge clk);
    if (timed_out) begin tests++; fails++; $display("FAIL watchdog actual=1 expected=0"); end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (timed_out);
    tests++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule